// File: doc/BRIEF.md
# Four-Bit-Coded Integer ALU

This block is the arithmetic-logic unit of a small load/store processor core. It is purely combinational. It takes two operands and a four-bit operation code, and it returns a result word and a flag that is high when the result is all zeros. The instruction decoder picks the operation code. It picks the add code for load and store address arithmetic and the subtract code for equality branches. The branch logic then reads the zero flag to decide whether the branch is taken.

Addition, subtraction and the signed less-than compare share one adder. The adder takes the second operand in complemented form when it has to subtract. The three bitwise operations come from a separate per-bit logic slice. A result selector chooses one of these values and derives the zero flag from the chosen word. Any code that is not assigned to an operation produces a result of zero. Arithmetic wraps modulo 2^WIDTH and raises no exception.

Top module: `int_alu4`

## Requirements
- R1: Code 4'b0000 drives the bitwise AND of the two operands onto the result.
- R2: Code 4'b0001 drives the bitwise OR of the two operands onto the result.
- R3: Code 4'b1100 drives the bitwise NOR of the two operands onto the result.
- R4: Code 4'b0010 drives the sum of the operands, wrapped modulo 2^WIDTH, onto the result.
- R5: Code 4'b0110 drives operand A minus operand B, wrapped modulo 2^WIDTH, onto the result.
- R6: Code 4'b0111 treats both operands as signed two's-complement values. It returns 1 in bit 0 when A is less than B, even when A minus B overflows, and returns 0 in bit 0 otherwise. All bits above bit 0 are zero.
- R7: Every code other than the six listed above gives a result of all zeros.
- R8: The zero flag is 1 exactly when every result bit is 0, for every code. In particular, subtracting equal operands raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand (minuend for subtract and compare) |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 4 | Operation code |
| result | output | WIDTH | Selected result word |
| is_zero | output | 1 | High when the result is all zeros |

## Verification
The checker runs immediate assertions on the settled combinational outputs. It assumes that operands and operation code carry only known 0/1 values, and it skips any evaluation in which an input is unknown. The bench keeps within this assumption. It drives every input to a defined value before the first check and changes operands and code together on the falling clock edge. It samples the outputs one nanosecond later, once they have settled. Stimulus covers all sixteen codes against signed and unsigned corner operands. It adds pseudo-random operands for the defined codes and an exhaustive sweep of a four-bit-wide instance.

// File: rtl/int_alu4_pkg.sv
package int_alu4_pkg;

    localparam int CTRL_W = 4;

    typedef enum logic [CTRL_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    // Subtract and compare both need A + ~B + 1 from the shared adder.
    function automatic logic op_needs_sub(input logic [CTRL_W-1:0] op);
        return (op == OP_SUB) || (op == OP_SLT);
    endfunction

endpackage

// File: rtl/int_alu4_addsub.sv
module int_alu4_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum,
    output logic             sgn_ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;

    always_comb begin
        b_eff   = do_sub ? ~in_b : in_b;
        sum     = in_a + b_eff + WIDTH'(do_sub);
        // Signed overflow: operands agree in sign, sum disagrees.
        sgn_ovf = (in_a[MSB] == b_eff[MSB]) && (sum[MSB] != in_a[MSB]);
    end

endmodule

// File: rtl/int_alu4_logic.sv
module int_alu4_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] and_v,
    output logic [WIDTH-1:0] or_v,
    output logic [WIDTH-1:0] nor_v
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            and_v[i] = in_a[i] & in_b[i];
            or_v[i]  = in_a[i] | in_b[i];
            nor_v[i] = ~(in_a[i] | in_b[i]);
        end
    end

endmodule

// File: rtl/int_alu4_select.sv
module int_alu4_select
    import int_alu4_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [CTRL_W-1:0] op,
    input  logic [WIDTH-1:0]  sum,
    input  logic              less,
    input  logic [WIDTH-1:0]  and_v,
    input  logic [WIDTH-1:0]  or_v,
    input  logic [WIDTH-1:0]  nor_v,
    output logic [WIDTH-1:0]  res,
    output logic              zero
);
    always_comb begin
        unique case (op)
            OP_AND:  res = and_v;
            OP_OR:   res = or_v;
            OP_NOR:  res = nor_v;
            OP_ADD:  res = sum;
            OP_SUB:  res = sum;
            OP_SLT:  res = WIDTH'(less);
            default: res = '0;
        endcase
        zero = ~|res;
    end

endmodule

// File: rtl/int_alu4.sv
module int_alu4
    import int_alu4_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]  opnd_a,
    input  logic [WIDTH-1:0]  opnd_b,
    input  logic [CTRL_W-1:0] op_sel,
    output logic [WIDTH-1:0]  result,
    output logic              is_zero
);
    localparam int MSB = WIDTH - 1;

    logic             sub_en;
    logic [WIDTH-1:0] sum_w;
    logic             ovf_w;
    logic             less_w;
    logic [WIDTH-1:0] and_w;
    logic [WIDTH-1:0] or_w;
    logic [WIDTH-1:0] nor_w;

    always_comb begin
        sub_en = op_needs_sub(op_sel);
        // Signed A < B: sign of A - B, corrected when it overflowed.
        less_w = sum_w[MSB] ^ ovf_w;
    end

    int_alu4_addsub #(.WIDTH(WIDTH)) u_addsub (
        .in_a    (opnd_a),
        .in_b    (opnd_b),
        .do_sub  (sub_en),
        .sum     (sum_w),
        .sgn_ovf (ovf_w)
    );

    int_alu4_logic #(.WIDTH(WIDTH)) u_logic (
        .in_a  (opnd_a),
        .in_b  (opnd_b),
        .and_v (and_w),
        .or_v  (or_w),
        .nor_v (nor_w)
    );

    int_alu4_select #(.WIDTH(WIDTH)) u_select (
        .op    (op_sel),
        .sum   (sum_w),
        .less  (less_w),
        .and_v (and_w),
        .or_v  (or_w),
        .nor_v (nor_w),
        .res   (result),
        .zero  (is_zero)
    );

endmodule

// File: rtl/int_alu4_chk.sv
module int_alu4_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             is_zero
);
    logic defined;

    always_comb begin
        defined = (op_sel == 4'b0000) || (op_sel == 4'b0001) ||
                  (op_sel == 4'b0010) || (op_sel == 4'b0110) ||
                  (op_sel == 4'b0111) || (op_sel == 4'b1100);
        if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
            if (op_sel == 4'b0000) p_and_r1: assert (result == (opnd_a & opnd_b));
            if (op_sel == 4'b0001) p_or_r2:  assert (result == (opnd_a | opnd_b));
            if (op_sel == 4'b1100) p_nor_r3: assert (result == ~(opnd_a | opnd_b));
            if (op_sel == 4'b0010) p_add_r4: assert (result == WIDTH'(opnd_a + opnd_b));
            if (op_sel == 4'b0110) p_sub_r5: assert (result == WIDTH'(opnd_a - opnd_b));
            if (op_sel == 4'b0111) begin
                p_slt_r6:       assert (result[0] == ($signed(opnd_a) < $signed(opnd_b)));
                p_slt_upper_r6: assert (result[WIDTH-1:1] == '0);
            end
            if (!defined) p_undef_zero_r7: assert (result == '0);
            p_zero_flag_r8: assert (is_zero == (result == '0));
        end
    end

endmodule

bind int_alu4 int_alu4_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .op_sel  (op_sel),
    .result  (result),
    .is_zero (is_zero)
);

// File: tb/test_int_alu4.sv
`timescale 1ns/1ps
module test_int_alu4;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst_n;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;

    logic [31:0] a32, b32, res32;
    logic [3:0]  op32;
    logic        z32;
    logic [3:0]  a4, b4, res4, op4;
    logic        z4;

    int_alu4 #(.WIDTH(32)) i_int_alu4 (
        .opnd_a(a32), .opnd_b(b32), .op_sel(op32), .result(res32), .is_zero(z32));

    int_alu4 #(.WIDTH(4)) i_int_alu4_w4 (
        .opnd_a(a4), .opnd_b(b4), .op_sel(op4), .result(res4), .is_zero(z4));

    logic [31:0] corner [10] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002,
                                 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                                 32'hFFFF_FFFE, 32'h1234_5678, 32'h8000_0001,
                                 32'h7FFF_FFFE};
    int defined_ops [6] = '{0, 1, 2, 6, 7, 12};

    function automatic string req_of(int op);
        case (op)
            0:       return "R1";
            1:       return "R2";
            12:      return "R3";
            2:       return "R4";
            6:       return "R5";
            7:       return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic longint model(int w, int op, longint a, longint b);
        longint mask = (longint'(1) << w) - 1;
        longint sa = (((a >> (w - 1)) & 1) != 0) ? a - (longint'(1) << w) : a;
        longint sb = (((b >> (w - 1)) & 1) != 0) ? b - (longint'(1) << w) : b;
        case (op)
            0:       return a & b;
            1:       return a | b;
            12:      return (~(a | b)) & mask;
            2:       return (a + b) & mask;
            6:       return (a - b) & mask;
            7:       return (sa < sb) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run32(int op, logic [31:0] a, logic [31:0] b);
        longint exp;
        @(negedge clk);
        op32 = 4'(op); a32 = a; b32 = b;
        #1;
        exp = model(32, op, longint'(a), longint'(b));
        check(req_of(op), $sformatf("w32 op=%0d a=%h b=%h", op, a, b), longint'(res32), exp);
        check("R8", "w32 zero flag", longint'(z32), (exp == 0) ? 1 : 0);
    endtask

    task automatic run4(int op, int a, int b);
        longint exp;
        @(negedge clk);
        op4 = 4'(op); a4 = 4'(a); b4 = 4'(b);
        #1;
        exp = model(4, op, longint'(a), longint'(b));
        check(req_of(op), $sformatf("w4 op=%0d a=%0d b=%0d", op, a, b), longint'(res4), exp);
        check("R8", "w4 zero flag", longint'(z4), (exp == 0) ? 1 : 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2468;
        rst_n = 1'b0;
        a32 = '0; b32 = '0; op32 = '0;
        a4 = '0; b4 = '0; op4 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: AND of zero operands is zero (R1) and raises the flag (R8).
        check("R1", "reset result", longint'(res32), 0);
        check("R8", "reset zero flag", longint'(z32), 1);
        rst_n = 1'b1;

        // Equal operands under subtract: equality branch taken (R5, R8).
        run32(6, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        // Compare across overflow: most negative vs 1 (R6).
        run32(7, 32'h8000_0000, 32'h0000_0001);
        run32(7, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        // Wrap on add and subtract (R4, R5).
        run32(2, 32'hFFFF_FFFF, 32'h0000_0001);
        run32(6, 32'h0000_0000, 32'h0000_0001);

        // All sixteen codes against corner operands (R1..R8, undefined codes R7).
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run32(op, corner[i], corner[j]);

        // Pseudo-random operands for defined codes.
        for (int k = 0; k < 200; k++) begin
            logic [31:0] ra, rb;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            ra = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            rb = (k % 7 == 0) ? ra : lfsr;
            for (int d = 0; d < 6; d++)
                run32(defined_ops[d], ra, rb);
        end

        // Exhaustive sweep of the narrow instance.
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run4(op, a, b);

        finished = 1;
        summary();
        $finish;
    end

endmodule